// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides a fast clock by an integer ratio N and gives one output pulse, one input cycle wide, for every N input cycles. It is the integer core of a fractional-N synthesizer loop. A modulator upstream presents a fresh ratio for each output period. The block splits N into a coarse count P and a swallow count S, with N = 8·P + S. The high bits of the ratio word carry P and its three low bits carry S.

A dual-modulus prescaler divides by 8 or by 9. Its synchronous front is a 2/3 core. Behind the core sits a chain of toggle stages, each halving the rate of the one before it. A coarse counter counts prescaler periods. A swallow counter keeps the prescaler at 9 for the first S of those periods. Both counters reload together at the prescaler boundary that ends the last coarse period. The output pulse marks that same boundary, so a ratio change always takes effect on a whole period.

The ratio input is sampled only on the clock edge where the output pulse is registered. A new value is therefore presented after a pulse and takes effect for the period that begins with the next pulse.

Top module: `pswallow_div`

## Requirements
- R1: For a ratio word N in 180..230, the gap between consecutive rising edges of `div_o` is exactly N input cycles. P is `ratio_i[7:3]`, S is `ratio_i[2:0]`, and N = 8·P + S.
- R2: `div_o` is high for exactly one input cycle per output period.
- R3: `ratio_i` is sampled on the clock edge that raises `div_o`. The sampled value sets the length of the interval up to the next pulse. Consecutive periods may each use a different ratio.
- R4: Each prescaler period lasts 9 input cycles while the modulus select is active, and 8 input cycles otherwise.
- R5: Within one output period, the first S prescaler periods use modulus 9 and the remaining P−S use modulus 8. This covers both S = 0 (all periods at 8) and S = 7.
- R6: Changes to `ratio_i` between two sampling edges have no effect on the period that is running.
- R7: While `rst_ni` is low, `div_o` is low and all counters are zero. After release, the first pulse comes 8 input cycles later and loads the ratio present on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ratio_i | input | 8 | Division ratio N: P in bits 7:3, S in bits 2:0 |
| div_o | output | 1 | One-cycle pulse every N input cycles |

## Verification
Two events share one clock edge: the last prescaler boundary of an output period, and the reload of both counters from `ratio_i`. On that same edge, the freshly loaded swallow count must already steer the modulus for the very first prescaler period of the new output period. The bench provokes this with back-to-back ratios whose swallow counts alternate between 0 and 7, and between the range ends 180 and 230. It changes the ratio right after every pulse and also mid-period. It judges the result by counting the input cycles between pulses and comparing each gap with the ratio the bench knows was present at the preceding pulse.

// File: rtl/psd_pkg.sv
package psd_pkg;
  // Coarse part of a ratio word: number of prescaler periods.
  function automatic int unsigned ratio_hi(int unsigned n, int unsigned mlog);
    return n >> mlog;
  endfunction

  // Swallow part of a ratio word: periods spent at modulus M+1.
  function automatic int unsigned ratio_lo(int unsigned n, int unsigned mlog);
    return n & ((32'd1 << mlog) - 32'd1);
  endfunction

  // Total ratio produced by a coarse/swallow pair with base modulus 2**mlog.
  function automatic int unsigned ratio_of(int unsigned p, int unsigned s, int unsigned mlog);
    return (p << mlog) + s;
  endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
  parameter int unsigned TAIL_STG = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mod_sel_i,
  output logic       core_tc_o,
  output logic       pre_tc_o,
  output logic       tail_full_o,
  output logic [1:0] core_ph_o
);
  logic [1:0]          ph_q;
  logic [TAIL_STG-1:0] tq;
  logic [TAIL_STG:0]   carry;
  logic                swallow_now;

  // 2/3 synchronous core: extends to three cycles once per prescaler period.
  assign tail_full_o = &tq;
  assign swallow_now = mod_sel_i & tail_full_o;
  assign core_tc_o   = swallow_now ? (ph_q == 2'd2) : (ph_q == 2'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ph_q <= 2'd0;
    else if (core_tc_o) ph_q <= 2'd0;
    else                ph_q <= ph_q + 2'd1;
  end

  // Divide-by-2 tail: each stage toggles on the carry rippling from the one below.
  assign carry[0] = core_tc_o;
  for (genvar g = 0; g < TAIL_STG; g++) begin : g_tail
    assign carry[g+1] = carry[g] & tq[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       tq[g] <= 1'b0;
      else if (carry[g]) tq[g] <= ~tq[g];
    end
  end

  assign pre_tc_o  = carry[TAIL_STG];
  assign core_ph_o = ph_q;
endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl #(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned MOD_LOG = 3,
  localparam int unsigned P_W    = RATIO_W - MOD_LOG
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pre_tc_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               mod_sel_o,
  output logic               last_o,
  output logic               load_o,
  output logic [P_W-1:0]     pcnt_o,
  output logic [MOD_LOG-1:0] scnt_o
);
  logic [P_W-1:0]     pcnt_q, pload;
  logic [MOD_LOG-1:0] scnt_q, sload;

  assign pload = P_W'(psd_pkg::ratio_hi(32'(ratio_i), MOD_LOG) - 32'd1);
  assign sload = MOD_LOG'(psd_pkg::ratio_lo(32'(ratio_i), MOD_LOG));

  assign last_o    = (pcnt_q == '0);
  assign load_o    = pre_tc_i & last_o;
  assign mod_sel_o = (scnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      scnt_q <= '0;
    end else if (load_o) begin
      pcnt_q <= pload;
      scnt_q <= sload;
    end else if (pre_tc_i) begin
      pcnt_q <= pcnt_q - 1'b1;
      if (mod_sel_o) scnt_q <= scnt_q - 1'b1;
    end
  end

  assign pcnt_o = pcnt_q;
  assign scnt_o = scnt_q;
endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int unsigned RATIO_W  = 8,
  parameter int unsigned TAIL_STG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               div_o
);
  localparam int unsigned MOD_LOG = TAIL_STG + 1;
  localparam int unsigned P_W     = RATIO_W - MOD_LOG;

  logic               mod_sel, core_tc, pre_tc, tail_full;
  logic [1:0]         core_ph;
  logic               last_period, load_evt;
  logic [P_W-1:0]     pcnt;
  logic [MOD_LOG-1:0] scnt;
  logic               div_q;

  psd_prescaler #(.TAIL_STG(TAIL_STG)) u_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mod_sel_i   (mod_sel),
    .core_tc_o   (core_tc),
    .pre_tc_o    (pre_tc),
    .tail_full_o (tail_full),
    .core_ph_o   (core_ph)
  );

  psd_swallow_ctrl #(.RATIO_W(RATIO_W), .MOD_LOG(MOD_LOG)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pre_tc_i  (pre_tc),
    .ratio_i   (ratio_i),
    .mod_sel_o (mod_sel),
    .last_o    (last_period),
    .load_o    (load_evt),
    .pcnt_o    (pcnt),
    .scnt_o    (scnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= 1'b0;
    else         div_q <= load_evt;
  end

  assign div_o = div_q;
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int unsigned RATIO_W  = 8,
  parameter int unsigned TAIL_STG = 2,
  localparam int unsigned MOD_LOG = TAIL_STG + 1,
  localparam int unsigned P_W     = RATIO_W - MOD_LOG,
  localparam int unsigned CYC_W   = MOD_LOG + 2,
  localparam int unsigned MODV    = 1 << MOD_LOG
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               div_o,
  input logic               pre_tc,
  input logic               mod_sel,
  input logic               tail_full,
  input logic               last_period,
  input logic [1:0]         core_ph,
  input logic [P_W-1:0]     pcnt,
  input logic [MOD_LOG-1:0] scnt
);
  logic [CYC_W-1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc <= CYC_W'(1);
    else if (pre_tc) cyc <= CYC_W'(1);
    else             cyc <= cyc + 1'b1;
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_o |=> !div_o); // R2
  AST_PRE_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tc |-> (cyc == (mod_sel ? CYC_W'(MODV + 1) : CYC_W'(MODV)))); // R4
  AST_CORE_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_ph == 2'd2) |-> (mod_sel && tail_full)); // R4
  AST_SWALLOW_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_tc && !last_period && mod_sel) |=> (scnt == MOD_LOG'($past(scnt) - 1'b1))); // R5
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcnt != $past(pcnt)) |-> $past(pre_tc)); // R6
  AST_PULSE_AT_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_o) |-> $past(pre_tc && last_period)); // R3
endmodule

bind pswallow_div psd_checker #(.RATIO_W(RATIO_W), .TAIL_STG(TAIL_STG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .div_o       (div_o),
  .pre_tc      (pre_tc),
  .mod_sel     (mod_sel),
  .tail_full   (tail_full),
  .last_period (last_period),
  .core_ph     (core_ph),
  .pcnt        (pcnt),
  .scnt        (scnt)
);

// File: tb/pswallow_div_bench.sv
`timescale 1ns/1ps
module pswallow_div_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] ratio_i = 8'd200;
  logic       div_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;
  int unsigned loaded;

  localparam int unsigned VEC_N = 10;
  localparam int unsigned VEC [VEC_N] = '{180, 230, 184, 223, 181, 229, 216, 199, 186, 221};

  pswallow_div u_pswallow_div (.clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i), .div_o(div_o));

  always #2.5 clk_i = ~clk_i;

  task automatic check(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until div_o is seen high, starting from a given count.
  task automatic wait_pulse(input int unsigned start, output int unsigned cyc);
    cyc = start;
    do begin
      @(negedge clk_i);
      cyc++;
    end while (!div_o && cyc < 2000);
  endtask

  // Bench-side model of the ratio: N = 8*P + S.
  function automatic int unsigned expect_gap(int unsigned n);
    return (n / 8) * 8 + (n % 8);
  endfunction

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int unsigned gap;
    // R7: output quiet in reset
    repeat (4) @(negedge clk_i);
    check("R7 reset low", div_o, 0);
    rst_ni = 1'b1;
    wait_pulse(0, gap);
    check("R7 first pulse", gap, 8);
    loaded = 200;

    // Table walk: new ratio after every pulse (R1, R3, R5 with S=0 and S=7)
    for (int i = 0; i < VEC_N; i++) begin
      ratio_i = 8'(VEC[i]);
      @(negedge clk_i);
      check("R2 width", div_o, 0);
      wait_pulse(1, gap);
      check("R1 R3 R5 gap", gap, expect_gap(loaded));
      loaded = VEC[i];
    end

    // R6: mid-period changes do not disturb the running period
    ratio_i = 8'd190;
    repeat (50) @(negedge clk_i);
    ratio_i = 8'd215;
    wait_pulse(50, gap);
    check("R6 running period", gap, loaded);
    loaded = 215;
    @(negedge clk_i);
    check("R2 width", div_o, 0);
    repeat (20) @(negedge clk_i);
    ratio_i = 8'd182;
    wait_pulse(21, gap);
    check("R3 late change", gap, 215);
    loaded = 182;

    // R7: reset mid-run
    repeat (30) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R7 reset mid", div_o, 0);
    ratio_i = 8'd207;
    rst_ni = 1'b1;
    wait_pulse(0, gap);
    check("R7 restart", gap, 8);
    @(negedge clk_i);
    wait_pulse(1, gap);
    check("R1 after restart", gap, 207);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule